// File: doc/BRIEF.md
# DRAM Bank Command Sequencer

This block drives the command bus of a single synchronous DRAM bank on behalf of a simple read-request port. A request carries a row and a column address. The sequencer decides whether the target row is already open, closes a different open row when needed, opens the target row, issues the column read, and raises a one-cycle data-valid strobe in the cycle that read data is due. Between any two commands it waits out the minimum spacing the DRAM needs, and every one of those spacings is taken from run-time configuration inputs rather than from elaboration-time constants.

Only one request is in flight at a time. Chip select is raised when a request is taken. The first command then waits one or two extra cycles, as selected by a configuration bit. A row stays open after its read so that a following read to the same row can go straight to the column read. The row cannot be closed before its minimum active time has run out, even when nothing else is pending. Configuration values below 2 are raised to 2. A warning output flags a row-active time that is shorter than the sum of the row-to-column delay, the read latency and 2. The configuration is captured only while the sequencer is idle.

Top module: `dram_bank_seq`

## Requirements
- R1: Chip select (`cmd_cs`) rises in the cycle after a request is accepted and stays high up to, but not including, the strobe cycle. The first command of the request appears 1 cycle after chip select rises when `cfg_rate2`=0, and 2 cycles after when `cfg_rate2`=1.
- R2: A read command is issued no earlier than `cfg_trcd` cycles after the activate of its row.
- R3: `rd_valid` is high for exactly one cycle, `cfg_tcas` cycles after the read command.
- R4: An activate is issued no earlier than `cfg_trp` cycles after the preceding precharge.
- R5: A precharge is issued no earlier than `cfg_tras` cycles after the activate of the open row, even when that row's read finished long before.
- R6: The `cmd_op` encoding is 0 = no command, 1 = activate, 2 = read, 3 = precharge. A request to a closed or different row issues a precharge (only if a row is open), then an activate carrying the row on `cmd_row`, then a read carrying the column on `cmd_col`. Each command is issued in the earliest cycle that R1, R2, R4 and R5 allow.
- R7: A request to the row that is already open issues only the read, and the read is still subject to R2.
- R8: `cfg_warn` is high while the captured row-active time is below the captured row-to-column delay + read latency + 2, and low otherwise.
- R9: A timing input below 2 behaves exactly as the value 2.
- R10: `req_ready` goes low in the cycle after acceptance and stays low until the cycle of the request's `rd_valid` strobe.
- R11: Timing inputs are captured only while idle. A change made while a request is in progress does not alter that request's command timing.
- R12: Synchronous active-high `rst` returns the block to idle: no row open, all delay counters cleared, no command, chip select low, `req_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rate2 | input | 1 | 1 selects a two-cycle command rate after chip select, 0 selects one cycle |
| cfg_trcd | input | TW | Activate-to-read delay in cycles |
| cfg_tcas | input | TW | Read-to-data latency in cycles |
| cfg_trp | input | TW | Precharge-to-activate delay in cycles |
| cfg_tras | input | TW | Minimum activate-to-precharge time in cycles |
| req_valid | input | 1 | Read request present |
| req_row | input | RW | Row address of the request |
| req_col | input | CW | Column address of the request |
| req_ready | output | 1 | Sequencer can accept a request |
| cmd_cs | output | 1 | Chip select |
| cmd_op | output | 2 | Command code (see R6) |
| cmd_row | output | RW | Row address, meaningful with an activate |
| cmd_col | output | CW | Column address, meaningful with a read |
| rd_valid | output | 1 | Read data is due in this cycle |
| cfg_warn | output | 1 | Row-active time below the recommended minimum |

## Verification
The hardest situation to reach is a row miss that arrives while the open row's minimum active time is still running, so that the precharge is held back by that time and not by the command-rate delay. The stimulus programs a row-active time far longer than the activate-read-data path and sends a miss right after a short read to the open row. A second hard case is a timing change in the middle of a sequence. The bench changes the delays a few cycles after acceptance and expects the timing captured at acceptance.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_ACT = 2'd1,
    CMD_RD  = 2'd2,
    CMD_PRE = 2'd3
  } dbs_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DATA = 2'd2
  } dbs_state_e;

  localparam int NUM_TIMERS = 4;
  localparam int TI_RCD = 0;
  localparam int TI_RAS = 1;
  localparam int TI_RP  = 2;
  localparam int TI_CAS = 3;
endpackage

// File: rtl/dbs_delay_timer.sv
module dbs_delay_timer #(
  parameter int TW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - TW'(1);
    end
  end

  assign expired = (cnt == '0);

  // R9: clamped delays always load at least one wait cycle
  p_load_waits_r9: assert property (@(posedge clk) disable iff (rst)
    load |=> !expired);
endmodule

// File: rtl/dbs_cfg_shadow.sv
module dbs_cfg_shadow #(
  parameter int TW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sample,
  input  logic          in_rate2,
  input  logic [TW-1:0] in_rcd,
  input  logic [TW-1:0] in_cas,
  input  logic [TW-1:0] in_rp,
  input  logic [TW-1:0] in_ras,
  output logic          sh_rate2,
  output logic [TW-1:0] sh_rcd,
  output logic [TW-1:0] sh_cas,
  output logic [TW-1:0] sh_rp,
  output logic [TW-1:0] sh_ras,
  output logic          warn
);
  localparam int SW = TW + 2;
  localparam logic [TW-1:0] MIN_VAL = TW'(2);

  function automatic logic [TW-1:0] floor2(input logic [TW-1:0] v);
    return (v < MIN_VAL) ? MIN_VAL : v;
  endfunction

  logic [SW-1:0] need_ras;
  assign need_ras = SW'(sh_rcd) + SW'(sh_cas) + SW'(2);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_rate2 <= 1'b0;
      sh_rcd   <= MIN_VAL;
      sh_cas   <= MIN_VAL;
      sh_rp    <= MIN_VAL;
      sh_ras   <= MIN_VAL;
      warn     <= 1'b0;
    end else begin
      if (sample) begin
        sh_rate2 <= in_rate2;
        sh_rcd   <= floor2(in_rcd);
        sh_cas   <= floor2(in_cas);
        sh_rp    <= floor2(in_rp);
        sh_ras   <= floor2(in_ras);
      end
      warn <= (SW'(sh_ras) < need_ras);
    end
  end

  p_hold_cfg_r11: assert property (@(posedge clk) disable iff (rst)
    !sample |=> ($stable(sh_rcd) && $stable(sh_cas) && $stable(sh_rp) &&
                 $stable(sh_ras) && $stable(sh_rate2)));
endmodule

// File: rtl/dbs_row_tracker.sv
module dbs_row_tracker #(
  parameter int RW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          open_set,
  input  logic          open_clr,
  input  logic [RW-1:0] set_row,
  input  logic [RW-1:0] cmp_row,
  output logic          is_open,
  output logic          hit
);
  logic [RW-1:0] cur_row;

  always_ff @(posedge clk) begin
    if (rst) begin
      is_open <= 1'b0;
      cur_row <= '0;
    end else if (open_set) begin
      is_open <= 1'b1;
      cur_row <= set_row;
    end else if (open_clr) begin
      is_open <= 1'b0;
    end
  end

  assign hit = is_open && (cur_row == cmp_row);

  p_track_r7: assert property (@(posedge clk) disable iff (rst)
    open_set |=> (is_open && cur_row == $past(set_row)));
endmodule

// File: rtl/dram_bank_seq.sv
module dram_bank_seq
  import dbs_pkg::*;
#(
  parameter int TW = 5,
  parameter int RW = 13,
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_rate2,
  input  logic [TW-1:0] cfg_trcd,
  input  logic [TW-1:0] cfg_tcas,
  input  logic [TW-1:0] cfg_trp,
  input  logic [TW-1:0] cfg_tras,
  input  logic          req_valid,
  input  logic [RW-1:0] req_row,
  input  logic [CW-1:0] req_col,
  output logic          req_ready,
  output logic          cmd_cs,
  output logic [1:0]    cmd_op,
  output logic [RW-1:0] cmd_row,
  output logic [CW-1:0] cmd_col,
  output logic          rd_valid,
  output logic          cfg_warn
);
  localparam int NT = NUM_TIMERS;

  dbs_state_e state;
  dbs_cmd_e   pend;
  dbs_cmd_e   last_cmd;
  logic       cs_wait;
  logic [RW-1:0] lat_row;
  logic [CW-1:0] lat_col;

  logic          sh_rate2;
  logic [TW-1:0] sh_rcd, sh_cas, sh_rp, sh_ras;
  logic          row_open, row_hit;

  logic [NT-1:0]         tload;
  logic [NT-1:0]         tzero;
  logic [NT-1:0][TW-1:0] tval;

  logic gate, issue_act, issue_rd, issue_pre, accept;

  dbs_cfg_shadow #(.TW(TW)) u_cfg (
    .clk(clk), .rst(rst), .sample(state == ST_IDLE),
    .in_rate2(cfg_rate2), .in_rcd(cfg_trcd), .in_cas(cfg_tcas),
    .in_rp(cfg_trp), .in_ras(cfg_tras),
    .sh_rate2(sh_rate2), .sh_rcd(sh_rcd), .sh_cas(sh_cas),
    .sh_rp(sh_rp), .sh_ras(sh_ras), .warn(cfg_warn)
  );

  dbs_row_tracker #(.RW(RW)) u_rows (
    .clk(clk), .rst(rst), .open_set(issue_act), .open_clr(issue_pre),
    .set_row(lat_row), .cmp_row(req_row), .is_open(row_open), .hit(row_hit)
  );

  // delay timers: loaded with delay-1 when the starting command issues
  always_comb begin
    tload         = '0;
    tval          = '0;
    tload[TI_RCD] = issue_act;
    tval[TI_RCD]  = sh_rcd - TW'(1);
    tload[TI_RAS] = issue_act;
    tval[TI_RAS]  = sh_ras - TW'(1);
    tload[TI_RP]  = issue_pre;
    tval[TI_RP]   = sh_rp - TW'(1);
    tload[TI_CAS] = issue_rd;
    tval[TI_CAS]  = sh_cas - TW'(1);
  end

  for (genvar gi = 0; gi < NT; gi++) begin : g_timer
    dbs_delay_timer #(.TW(TW)) u_tmr (
      .clk(clk), .rst(rst), .load(tload[gi]), .load_val(tval[gi]),
      .expired(tzero[gi])
    );
  end

  always_comb begin
    gate = 1'b0;
    if (state == ST_RUN && !cs_wait) begin
      case (pend)
        CMD_PRE: gate = tzero[TI_RAS];
        CMD_ACT: gate = tzero[TI_RP];
        CMD_RD:  gate = tzero[TI_RCD];
        default: gate = 1'b0;
      endcase
    end
  end

  assign issue_act = gate && (pend == CMD_ACT);
  assign issue_rd  = gate && (pend == CMD_RD);
  assign issue_pre = gate && (pend == CMD_PRE);
  assign accept    = (state == ST_IDLE) && req_valid;
  assign req_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      pend     <= CMD_NOP;
      last_cmd <= CMD_NOP;
      cs_wait  <= 1'b0;
      lat_row  <= '0;
      lat_col  <= '0;
      cmd_cs   <= 1'b0;
      cmd_op   <= CMD_NOP;
      cmd_row  <= '0;
      cmd_col  <= '0;
      rd_valid <= 1'b0;
    end else begin
      cmd_op   <= CMD_NOP;
      rd_valid <= 1'b0;
      cs_wait  <= 1'b0;
      if (cmd_op != CMD_NOP) last_cmd <= dbs_cmd_e'(cmd_op);
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state   <= ST_RUN;
            cmd_cs  <= 1'b1;
            cs_wait <= sh_rate2;
            lat_row <= req_row;
            lat_col <= req_col;
            pend    <= row_hit ? CMD_RD : (row_open ? CMD_PRE : CMD_ACT);
          end
        end
        ST_RUN: begin
          if (gate) begin
            cmd_op  <= pend;
            cmd_row <= lat_row;
            cmd_col <= lat_col;
            case (pend)
              CMD_PRE: pend <= CMD_ACT;
              CMD_ACT: pend <= CMD_RD;
              default: begin
                pend  <= CMD_NOP;
                state <= ST_DATA;
              end
            endcase
          end
        end
        ST_DATA: begin
          if (tzero[TI_CAS]) begin
            rd_valid <= 1'b1;
            cmd_cs   <= 1'b0;
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_cs_before_cmd_r1: assert property (@(posedge clk) disable iff (rst)
    (cmd_op != CMD_NOP) |-> (cmd_cs && $past(cmd_cs)));
  p_cs_two_cycle_r1: assert property (@(posedge clk) disable iff (rst)
    (cmd_op != CMD_NOP && sh_rate2) |-> $past(cmd_cs, 2));
  p_strobe_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);
  p_read_after_act_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_op == CMD_RD) |-> (last_cmd == CMD_ACT || last_cmd == CMD_RD));
  p_no_double_act_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_op == CMD_ACT) |-> (last_cmd != CMD_ACT));
  p_busy_until_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(!req_ready));
endmodule

// File: tb/dram_bank_seq_tb.sv
module dram_bank_seq_tb;
  localparam int TW = 5;
  localparam int RW = 13;
  localparam int CW = 10;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst;
  logic          cfg_rate2;
  logic [TW-1:0] cfg_trcd, cfg_tcas, cfg_trp, cfg_tras;
  logic          req_valid;
  logic [RW-1:0] req_row;
  logic [CW-1:0] req_col;
  logic          req_ready, cmd_cs, rd_valid, cfg_warn;
  logic [1:0]    cmd_op;
  logic [RW-1:0] cmd_row;
  logic [CW-1:0] cmd_col;

  dram_bank_seq #(.TW(TW), .RW(RW), .CW(CW)) u_dut (
    .clk(clk), .rst(rst), .cfg_rate2(cfg_rate2), .cfg_trcd(cfg_trcd),
    .cfg_tcas(cfg_tcas), .cfg_trp(cfg_trp), .cfg_tras(cfg_tras),
    .req_valid(req_valid), .req_row(req_row), .req_col(req_col),
    .req_ready(req_ready), .cmd_cs(cmd_cs), .cmd_op(cmd_op),
    .cmd_row(cmd_row), .cmd_col(cmd_col), .rd_valid(rd_valid),
    .cfg_warn(cfg_warn)
  );

  typedef struct {
    int    op;   // 1 act, 2 read, 3 precharge, 4 strobe
    int    cyc;
    int    row;
    int    col;
    string tag;
  } exp_t;

  exp_t sbq[$];
  int ecount = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit m_open = 1'b0;
  int m_row = 0;
  int m_act = -1000;
  int m_pre = -1000;

  always @(posedge clk) ecount <= ecount + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int fl2(input int v);
    return (v < 2) ? 2 : v;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic push(input int op, input int cyc, input int row,
                      input int col, input string tag);
    exp_t e;
    e.op = op; e.cyc = cyc; e.row = row; e.col = col; e.tag = tag;
    sbq.push_back(e);
  endtask

  // driver: accepts one request and predicts its command stream
  task automatic do_req(input int row, input int col, input string tag);
    int rcd, cas, rp, ras, rate, c0, t, pre, act, rd;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    rcd  = fl2(int'(cfg_trcd));
    cas  = fl2(int'(cfg_tcas));
    rp   = fl2(int'(cfg_trp));
    ras  = fl2(int'(cfg_tras));
    rate = cfg_rate2 ? 2 : 1;
    req_valid = 1'b1;
    req_row   = RW'(row);
    req_col   = CW'(col);
    c0 = ecount + 1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R10", "ready after accept", int'(req_ready), 0);
    chk(cmd_cs == 1'b1, "R1", "cs after accept", int'(cmd_cs), 1);
    t = c0 + rate;
    if (m_open && m_row == row) begin
      rd = imax(t, m_act + rcd);
      push(2, rd, row, col, {tag, " R7 hit read"});
    end else begin
      if (m_open) begin
        pre = imax(t, m_act + ras);
        push(3, pre, row, col, {tag, " R5 precharge"});
        m_pre = pre;
        act = pre + rp;
      end else begin
        act = imax(t, m_pre + rp);
      end
      push(1, act, row, col, {tag, " R4 R6 activate"});
      m_act  = act;
      m_open = 1'b1;
      m_row  = row;
      rd = act + rcd;
      push(2, rd, row, col, {tag, " R2 read"});
    end
    push(4, rd + cas, row, col, {tag, " R3 strobe"});
  endtask

  task automatic wait_done();
    @(negedge clk);
    while (sbq.size() != 0 || !req_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic set_cfg(input int r2, input int rcd, input int cas,
                         input int rp, input int ras);
    cfg_rate2 = r2[0];
    cfg_trcd  = TW'(rcd);
    cfg_tcas  = TW'(cas);
    cfg_trp   = TW'(rp);
    cfg_tras  = TW'(ras);
    repeat (4) @(negedge clk);
  endtask

  // monitor: pops the scoreboard as commands and strobes appear
  always @(negedge clk) begin : mon
    exp_t e;
    int   op;
    if (!rst && (cmd_op != 2'd0 || rd_valid)) begin
      op = rd_valid ? 4 : int'(cmd_op);
      if (sbq.size() == 0) begin
        chk(1'b0, "R6", "unexpected event op", op, 0);
      end else begin
        e = sbq.pop_front();
        chk(op == e.op, e.tag, "op", op, e.op);
        chk(ecount == e.cyc, e.tag, "cycle", ecount, e.cyc);
        if (op != 4) chk(cmd_cs == 1'b1, "R1", "cs with command", int'(cmd_cs), 1);
        if (op == 1) chk(int'(cmd_row) == e.row, e.tag, "row", int'(cmd_row), e.row);
        if (op == 2) chk(int'(cmd_col) == e.col, e.tag, "col", int'(cmd_col), e.col);
        if (op == 4) begin
          chk(req_ready == 1'b1, "R10", "ready at strobe", int'(req_ready), 1);
          chk(cmd_cs == 1'b0, "R1", "cs at strobe", int'(cmd_cs), 0);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    rst = 1'b1;
    req_valid = 1'b0;
    req_row = '0;
    req_col = '0;
    cfg_rate2 = 1'b0;
    cfg_trcd = TW'(3);
    cfg_tcas = TW'(3);
    cfg_trp  = TW'(3);
    cfg_tras = TW'(20);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12: reset state
    chk(req_ready == 1'b1, "R12", "ready", int'(req_ready), 1);
    chk(cmd_cs == 1'b0, "R12", "cs", int'(cmd_cs), 0);
    chk(cmd_op == 2'd0, "R12", "op", int'(cmd_op), 0);
    chk(rd_valid == 1'b0, "R12", "strobe", int'(rd_valid), 0);
    repeat (3) @(negedge clk);
    chk(cfg_warn == 1'b0, "R8", "warn tras 20", int'(cfg_warn), 0);

    do_req(5, 1, "miss-empty");
    wait_done();
    do_req(5, 2, "hit");
    wait_done();
    do_req(7, 3, "miss-tras-hold");   // R5: precharge held by tRAS
    wait_done();

    set_cfg(1, 3, 3, 6, 20);           // R1 two-cycle rate, long tRP (R4)
    do_req(7, 9, "rate2-hit");
    wait_done();
    do_req(9, 4, "rate2-miss");
    wait_done();

    set_cfg(0, 2, 2, 2, 5);            // R8: 5 < 2+2+2
    chk(cfg_warn == 1'b1, "R8", "warn tras 5", int'(cfg_warn), 1);
    set_cfg(0, 2, 2, 2, 6);
    chk(cfg_warn == 1'b0, "R8", "warn tras 6", int'(cfg_warn), 0);

    set_cfg(0, 0, 1, 1, 0);            // R9: all behave as 2
    chk(cfg_warn == 1'b1, "R9", "warn clamped", int'(cfg_warn), 1);
    do_req(11, 5, "clamp-miss");
    wait_done();
    do_req(11, 6, "clamp-hit");
    wait_done();

    set_cfg(0, 4, 4, 3, 12);
    do_req(13, 7, "mid-change");       // R11: change after accept
    repeat (2) @(negedge clk);
    cfg_trcd = TW'(9);
    cfg_tcas = TW'(9);
    cfg_tras = TW'(2);
    cfg_rate2 = 1'b1;
    wait_done();
    set_cfg(0, 4, 4, 3, 12);
    do_req(2, 8, "after-change");
    wait_done();

    // R12: reset closes the row, next request needs an activate
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_open = 1'b0;
    m_act = -1000;
    m_pre = -1000;
    @(negedge clk);
    chk(req_ready == 1'b1, "R12", "ready after reset", int'(req_ready), 1);
    do_req(2, 9, "R12 post-reset");
    wait_done();

    chk(sbq.size() == 0, "R6", "leftover expected", sbq.size(), 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule